// File: doc/BRIEF.md
# Steered Reset-Interrupt Packet Dispatcher

This block fans an externally requested reset interrupt out to a chosen set of hardware threads. When the active-low request input goes from high to low, the block snapshots a 64-bit thread mask. It then issues one interrupt packet for each set bit of that snapshot, on a valid/ready output toward the cores. Each packet names its target thread. The 6-bit thread index is split into a 3-bit core number and a 3-bit thread-within-core number.

The scan visits the snapshot from the lowest index upward. A priority encoder picks the lowest pending bit and clears it on acceptance, so packets can leave on consecutive cycles when ready stays high. A one-cycle done flag closes each dispatch. Requests that arrive while a dispatch is running are ignored.

Top module: `rstint_fanout`

## Requirements
- R1: The mask is captured on the first clock edge at which req_ni is sampled low after being sampled high, provided no dispatch is pending. Later mask_i values have no effect on that dispatch.
- R2: The number of packets accepted per dispatch equals the population count of the captured mask, and no packet follows done_o.
- R3: Packets are issued in strictly ascending thread index, and clear mask bits are skipped.
- R4: Every packet has bit 145 = 1, bits [144:141] = 4'b0111, bits [15:14] = 2'b01 and bits [5:0] = 6'b000011. All bits outside the fixed and identifier fields are 0.
- R5: For thread index t, bits [13:11] carry t[5:3]. Both bits [10:8] and bits [136:134] carry t[2:0].
- R6: An all-zero captured mask produces no packet, and done_o is high in the cycle after capture.
- R7: While pkt_valid_o is high and pkt_ready_i is low, the packet and valid stay unchanged in the next cycle.
- R8: The first packet is valid in the cycle after capture. With pkt_ready_i held high, one packet is accepted every cycle.
- R9: done_o is high for exactly one cycle, the cycle after the last packet is accepted. valid is low in that cycle.
- R10: A falling edge of req_ni while packets are pending is ignored. A request after done_o starts a new scan from index 0.
- R11: During and after reset, pkt_valid_o and done_o are 0 and pkt_data_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ni | input | 1 | Reset-interrupt request, active low; its falling edge starts a dispatch |
| mask_i | input | 64 | Thread steering mask, one bit per thread |
| pkt_valid_o | output | 1 | Packet valid |
| pkt_ready_i | input | 1 | Downstream ready; a packet is accepted when valid and ready are both high |
| pkt_data_o | output | 146 | Interrupt packet; all zeros when not valid |
| done_o | output | 1 | One-cycle pulse at the end of a dispatch |

## Verification
All 64 single-bit masks are swept. This separates every core/thread split and each field position, because a swapped or shifted field gives a different index. The empty, full, alternating and pseudo-random masks test the skip logic and the population count. They are run with ready held high, where exact cycle counts expose any dead cycle between packets. They are also run under pseudo-random backpressure, which tests that stalled packets are held. In two runs a second request falls and the mask input changes mid-dispatch; an extra or reordered packet would show that such a request restarted the scan.

// File: rtl/rstint_pkg.sv
package rstint_pkg;
  localparam int PKT_W = 146;

  // Packet layout; positions are decoded by the receiving cores.
  localparam int VLD_BIT = 145;
  localparam int KIND_LSB = 141;
  localparam int KIND_W = 4;
  localparam logic [KIND_W-1:0] KIND_CODE = 4'b0111;
  localparam int THR_HI_LSB = 134;
  localparam int TAG_LSB = 14;
  localparam int TAG_W = 2;
  localparam logic [TAG_W-1:0] TAG_CODE = 2'b01;
  localparam int CORE_LSB = 11;
  localparam int THR_LO_LSB = 8;
  localparam int VEC_LSB = 0;
  localparam int VEC_W = 6;
  localparam logic [VEC_W-1:0] VEC_CODE = 6'b000011;
endpackage

// File: rtl/rstint_lsb_enc.sv
module rstint_lsb_enc #(
  parameter int N = 64,
  parameter int W = 6
) (
  input  logic [N-1:0] vec_i,
  output logic         any_o,
  output logic [N-1:0] onehot_o,
  output logic [W-1:0] idx_o
);
  assign any_o    = |vec_i;
  assign onehot_o = vec_i & (~vec_i + N'(1));

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [N-1:0] sel;
    for (genvar n = 0; n < N; n++) begin : g_sel
      if (((n >> b) & 1) != 0) begin : g_on
        assign sel[n] = onehot_o[n];
      end else begin : g_off
        assign sel[n] = 1'b0;
      end
    end
    assign idx_o[b] = |sel;
  end
endmodule

// File: rtl/rstint_pend_reg.sv
module rstint_pend_reg #(
  parameter int N = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N-1:0] load_val_i,
  input  logic         clr_i,
  input  logic [N-1:0] clr_oh_i,
  output logic [N-1:0] pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_o <= '0;
    else if (load_i) pend_o <= load_val_i;
    else if (clr_i)  pend_o <= pend_o & ~clr_oh_i;
  end

  // a clear retires exactly one pending bit
  p_clr_hits_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> ($countones(clr_oh_i & pend_o) == 1));

  // a capture never lands on a live dispatch
  p_load_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (pend_o == '0));
endmodule

// File: rtl/rstint_pkt_fmt.sv
module rstint_pkt_fmt
  import rstint_pkg::*;
#(
  parameter int CORE_W = 3,
  parameter int THR_W  = 3
) (
  input  logic              vld_i,
  input  logic [CORE_W-1:0] core_i,
  input  logic [THR_W-1:0]  thr_i,
  output logic [PKT_W-1:0]  pkt_o
);
  always_comb begin
    pkt_o = '0;
    if (vld_i) begin
      pkt_o[VLD_BIT]                  = 1'b1;
      pkt_o[KIND_LSB +: KIND_W]       = KIND_CODE;
      pkt_o[TAG_LSB +: TAG_W]         = TAG_CODE;
      pkt_o[VEC_LSB +: VEC_W]         = VEC_CODE;
      pkt_o[CORE_LSB +: CORE_W]       = core_i;
      pkt_o[THR_LO_LSB +: THR_W]      = thr_i;
      pkt_o[THR_HI_LSB +: THR_W]      = thr_i;
    end
  end
endmodule

// File: rtl/rstint_fanout.sv
module rstint_fanout
  import rstint_pkg::*;
#(
  parameter int CORE_W = 3,
  parameter int THR_W  = 3,
  localparam int IDX_W = CORE_W + THR_W,
  localparam int NTHR  = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_ni,
  input  logic [NTHR-1:0]  mask_i,
  output logic             pkt_valid_o,
  input  logic             pkt_ready_i,
  output logic [PKT_W-1:0] pkt_data_o,
  output logic             done_o
);
  logic            req_prev_q;
  logic            req_fall, start, fire, last, busy;
  logic            done_q;
  logic [NTHR-1:0] pend_q, pick_oh, rest;
  logic [IDX_W-1:0] cur_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_prev_q <= 1'b1;
    else         req_prev_q <= req_ni;
  end

  assign req_fall = req_prev_q & ~req_ni;
  assign start    = req_fall & ~busy;   // requests during a dispatch are dropped

  rstint_pend_reg #(.N(NTHR)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .load_val_i (mask_i),
    .clr_i      (fire),
    .clr_oh_i   (pick_oh),
    .pend_o     (pend_q)
  );

  rstint_lsb_enc #(.N(NTHR), .W(IDX_W)) u_enc (
    .vec_i    (pend_q),
    .any_o    (busy),
    .onehot_o (pick_oh),
    .idx_o    (cur_idx)
  );

  rstint_pkt_fmt #(.CORE_W(CORE_W), .THR_W(THR_W)) u_fmt (
    .vld_i  (busy),
    .core_i (cur_idx[IDX_W-1:THR_W]),
    .thr_i  (cur_idx[THR_W-1:0]),
    .pkt_o  (pkt_data_o)
  );

  assign pkt_valid_o = busy;
  assign fire        = busy & pkt_ready_i;
  assign rest        = pend_q & ~pick_oh;
  assign last        = fire & ~(|rest);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= last | (start & (mask_i == '0));
  end

  assign done_o = done_q;

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o && $stable(pkt_data_o)));

  p_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (pend_q == $past(mask_i)));

  p_target_live_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> pend_q[cur_idx]);

  p_ascend_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !last) |=> (cur_idx > $past(cur_idx)));

  p_one_per_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> ($countones(pend_q) == $past($countones(pend_q)) - 1));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !pkt_valid_o);

  p_ignore_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && req_fall && !fire) |=> $stable(pend_q));
endmodule

// File: tb/rstint_fanout_test.sv
module rstint_fanout_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_ni = 1'b1;
  logic [63:0]  mask_i = '0;
  logic         pkt_valid_o;
  logic         pkt_ready_i = 1'b0;
  logic [145:0] pkt_data_o;
  logic         done_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] lf = 16'hACE1;

  always #4 clk_i = ~clk_i;

  rstint_fanout uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_ni      (req_ni),
    .mask_i      (mask_i),
    .pkt_valid_o (pkt_valid_o),
    .pkt_ready_i (pkt_ready_i),
    .pkt_data_o  (pkt_data_o),
    .done_o      (done_o)
  );

  task automatic check(input bit ok, input string req, input logic [145:0] act, input logic [145:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [145:0] exp_pkt(input logic [5:0] t);
    logic [145:0] p = '0;
    p[145]     = 1'b1;
    p[144:141] = 4'b0111;
    p[15:14]   = 2'b01;
    p[5:0]     = 6'b000011;
    p[13:11]   = t[5:3];
    p[10:8]    = t[2:0];
    p[136:134] = t[2:0];
    return p;
  endfunction

  function automatic logic next_ready(input int rmode);
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return (rmode == 0) ? 1'b1 : lf[0];
  endfunction

  task automatic run_case(input logic [63:0] m, input int rmode, input bit glitch);
    int exp_idx[64];
    int n = 0;
    int k = 0;
    int cyc = 0;
    int last_acc = 0;
    bit fin = 0;
    bit prev_stall = 0;
    logic [145:0] prev_data = '0;
    logic [5:0] got;
    for (int b = 0; b < 64; b++) if (m[b]) begin exp_idx[n] = b; n++; end

    @(posedge clk_i); #1;
    mask_i = m; req_ni = 1'b0;
    @(posedge clk_i); #1;              // capture edge has passed
    req_ni = 1'b1; mask_i = ~m;        // R1: later mask must not matter
    pkt_ready_i = next_ready(rmode);
    while (!fin && cyc < 1000) begin
      @(negedge clk_i); cyc++;
      if (prev_stall)
        check(pkt_valid_o && pkt_data_o == prev_data, "R7 hold", pkt_data_o, prev_data);
      if (cyc == 1 && n > 0)
        check(pkt_valid_o, "R8 first packet latency", 146'(pkt_valid_o), 146'(1));
      if (pkt_valid_o && pkt_ready_i) begin
        got = {pkt_data_o[13:11], pkt_data_o[10:8]};
        if (k >= n) begin
          check(0, "R2 extra packet", pkt_data_o, '0);
        end else begin
          check(got == 6'(exp_idx[k]), "R1 R3 order", 146'(got), 146'(exp_idx[k]));
          check(pkt_data_o == exp_pkt(got), "R4 R5 encoding", pkt_data_o, exp_pkt(got));
          if (rmode == 0)
            check(cyc == k + 1, "R8 back-to-back", 146'(cyc), 146'(k + 1));
        end
        k++;
        last_acc = cyc;
      end
      if (done_o) begin
        fin = 1;
        check(k == n, "R2 packet count", 146'(k), 146'(n));
        check(!pkt_valid_o, "R9 done with valid", 146'(pkt_valid_o), 146'(0));
        if (n == 0)
          check(cyc == 1, "R6 empty mask done", 146'(cyc), 146'(1));
        else
          check(cyc == last_acc + 1, "R9 done timing", 146'(cyc), 146'(last_acc + 1));
      end
      prev_stall = pkt_valid_o && !pkt_ready_i;
      prev_data  = pkt_data_o;
      @(posedge clk_i); #1;
      pkt_ready_i = next_ready(rmode);
      if (glitch) begin
        if (cyc == 2) begin req_ni = 1'b0; mask_i = '1; end
        if (cyc == 3) req_ni = 1'b1;
      end
    end
    if (!fin) check(0, "R9 done never seen", 146'(k), 146'(n));
    for (int q = 0; q < 3; q++) begin
      @(negedge clk_i);
      check(!done_o && !pkt_valid_o, "R9 R10 quiet after done",
            146'({done_o, pkt_valid_o}), 146'(0));
    end
    pkt_ready_i = 1'b0;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clk_i);
    // R11: reset state
    check(!pkt_valid_o && !done_o && pkt_data_o == '0, "R11 reset", pkt_data_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!pkt_valid_o && !done_o && pkt_data_o == '0, "R11 after reset", pkt_data_o, '0);

    run_case(64'h0, 0, 0);                     // R6
    run_case(64'h0, 1, 0);
    for (int b = 0; b < 64; b++)
      run_case(64'h1 << b, b % 2, 0);          // R5 sweep
    run_case('1, 0, 0);
    run_case('1, 1, 0);
    run_case(64'h8000_0000_0000_0001, 0, 0);
    run_case(64'hAAAA_AAAA_AAAA_AAAA, 0, 0);
    run_case(64'h5555_5555_5555_5555, 1, 0);
    run_case(64'h0F0F_00FF_F000_0F0F, 1, 0);
    for (int t = 0; t < 4; t++) begin
      r = '0;
      for (int w = 0; w < 4; w++) begin
        void'(next_ready(1));
        r = {r[47:0], lf};
      end
      run_case(r, t % 2, 0);
    end
    // R10: request mid-dispatch with a new mask is ignored
    run_case('1, 1, 1);
    run_case(64'hAAAA_AAAA_AAAA_AAAA, 0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule